// File: doc/BRIEF.md
# Flash Access Protection Selector

This block sits between a flash controller's access path and its SEC-DED and parity checkers. For every access it decides how that access is protected. A 2-bit protection mode selects one of four policies. A 3-bit control tag is stored next to every flash word. On a write, the block produces the tag and the parity bit to store. A write can be a full-width write protected by ECC or a narrow write protected by parity. In ECC-only mode, narrow writes are refused.

On a read, the block takes the stored tag and decodes it by two-of-three majority. It then reports which checker's verdict applies and forwards the single-error and double-error status. It also decides whether a double error becomes a bus error. An optional corruption mask lets a test controller flip tag bits on their way out of storage. This exercises the majority vote. The ECC datapath supplies the single and double error indications. The parity check is done here as even parity over the read data.

Top module: `flash_prot_ctrl`

## Requirements
- R1: In mode 2'b11 (bypass), a read reports use_ecc_o=0, use_par_o=0, sec_o=0, ded_o=0 and bus_err_o=0, whatever the stored tag, the error inputs or the data.
- R2: A full-width write (wr_single_i=0) is accepted in every mode: wr_valid_o=1, wr_ctl_o=3'b000, wr_par_o=0.
- R3: A narrow write (wr_single_i=1) in modes 2'b01, 2'b10 and 2'b11 is accepted with wr_ctl_o=3'b111 and wr_par_o equal to the XOR of all wr_data_i bits (even parity).
- R4: A narrow write in mode 2'b00 is refused: wr_err_o=1, wr_valid_o=0, wr_ctl_o=0, wr_par_o=0.
- R5: In modes 2'b01 and 2'b10, a tag holding two or more ones selects the parity path (use_par_o=1, use_ecc_o=0). Otherwise the ECC path is selected (use_ecc_o=1, use_par_o=0).
- R6: On the ECC path, sec_o and ded_o equal ecc_sec_i and ecc_ded_i.
- R7: On the parity path, sec_o=0. ded_o=1 exactly when the XOR of rd_data_i and rd_par_i is 1.
- R8: bus_err_o equals ded_o in modes 2'b00 and 2'b01. In mode 2'b10, bus_err_o stays 0 while ded_o is still reported.
- R9: In mode 2'b00, every read selects the ECC path whatever the tag holds.
- R10: When flt_en_i=1, the tag is XORed with flt_mask_i before decoding. When flt_en_i=0, flt_mask_i has no effect.
- R11: Read results appear with rsp_valid_o exactly one cycle after rd_valid_i, and write results exactly one cycle after wr_req_i. In cycles without a request, all result flags are 0.
- R12: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Protection mode: 00 ECC only, 01 dynamic, 10 dynamic without bus error, 11 bypass |
| flt_en_i | input | 1 | Enables tag corruption |
| flt_mask_i | input | 3 | Bits to flip in the read tag |
| wr_req_i | input | 1 | Write request |
| wr_single_i | input | 1 | 1 = narrow parity write, 0 = full-width ECC write |
| wr_data_i | input | DW | Write data |
| wr_valid_o | output | 1 | Write accepted, tag and parity valid |
| wr_err_o | output | 1 | Write refused |
| wr_ctl_o | output | 3 | Tag to store |
| wr_par_o | output | 1 | Parity bit to store |
| rd_valid_i | input | 1 | Read data, tag and ECC status valid |
| rd_ctl_i | input | 3 | Stored tag |
| rd_data_i | input | DW | Read data |
| rd_par_i | input | 1 | Stored parity bit |
| ecc_sec_i | input | 1 | Corrected single error from the ECC datapath |
| ecc_ded_i | input | 1 | Double error from the ECC datapath |
| rsp_valid_o | output | 1 | Read verdict valid |
| use_ecc_o | output | 1 | ECC path applied |
| use_par_o | output | 1 | Parity path applied |
| sec_o | output | 1 | Single error reported |
| ded_o | output | 1 | Uncorrectable error reported |
| bus_err_o | output | 1 | Bus error raised |

## Verification
The only internal state is the output registers. A wrong path choice shows up as a wrong use_ecc_o or use_par_o pair on the response of the read that caused it, one cycle after rd_valid_i. A wrong majority or a wrong fault mask shows up only for tags with exactly one or two bits set. The bench therefore sweeps every tag against every mask and every mode. A dropped or wrongly raised bus error shows up in that same response cycle. No later cycle carries it, so each read is compared in its own cycle.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam int CTLW = 3;

  typedef enum logic [1:0] {
    MODE_ECC_ONLY = 2'b00,
    MODE_DYN      = 2'b01,
    MODE_DYN_QUIET = 2'b10,
    MODE_BYPASS   = 2'b11
  } prot_mode_e;

  localparam logic [CTLW-1:0] TAG_FULL   = 3'b000;
  localparam logic [CTLW-1:0] TAG_NARROW = 3'b111;

  typedef struct packed {
    logic use_ecc;
    logic use_par;
    logic sec;
    logic ded;
    logic bus_err;
  } rd_verdict_t;

  // two-of-three vote: 1 means the tag says "narrow write"
  function automatic logic tag_vote(input logic [CTLW-1:0] t);
    return (t[0] & t[1]) | (t[0] & t[2]) | (t[1] & t[2]);
  endfunction
endpackage

// File: rtl/fp_wr_ctl.sv
module fp_wr_ctl
  import flash_prot_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            req,
  input  logic            single,
  input  prot_mode_e      mode,
  input  logic [DW-1:0]   data,
  output logic            accept,
  output logic            refuse,
  output logic [CTLW-1:0] tag,
  output logic            par
);
  logic narrow_blocked;

  assign narrow_blocked = single && (mode == MODE_ECC_ONLY);
  assign accept = req && !narrow_blocked;
  assign refuse = req && narrow_blocked;

  always_comb begin
    tag = TAG_FULL;
    par = 1'b0;
    if (accept && single) begin
      tag = TAG_NARROW;
      par = ^data;
    end
  end
endmodule

// File: rtl/fp_rd_decode.sv
module fp_rd_decode
  import flash_prot_pkg::*;
#(
  parameter int DW         = 32,
  parameter bit HAS_FAULT  = 1'b1
) (
  input  prot_mode_e      mode,
  input  logic [CTLW-1:0] tag_raw,
  input  logic            flt_en,
  input  logic [CTLW-1:0] flt_mask,
  input  logic [DW-1:0]   data,
  input  logic            par_bit,
  input  logic            ecc_sec,
  input  logic            ecc_ded,
  output logic            vote_narrow,
  output logic            par_mismatch,
  output rd_verdict_t     verdict
);
  logic [CTLW-1:0] tag_seen;

  generate
    if (HAS_FAULT) begin : g_fault
      assign tag_seen = tag_raw ^ (flt_en ? flt_mask : '0);
    end else begin : g_nofault
      logic unused_flt;
      assign unused_flt = flt_en ^ (^flt_mask);
      assign tag_seen = tag_raw;
    end
  endgenerate

  assign vote_narrow  = tag_vote(tag_seen);
  assign par_mismatch = (^data) ^ par_bit;

  always_comb begin
    verdict = '0;
    unique case (mode)
      MODE_BYPASS: verdict = '0;
      MODE_ECC_ONLY: begin
        verdict.use_ecc = 1'b1;
        verdict.sec     = ecc_sec;
        verdict.ded     = ecc_ded;
      end
      default: begin
        if (vote_narrow) begin
          verdict.use_par = 1'b1;
          verdict.ded     = par_mismatch;
        end else begin
          verdict.use_ecc = 1'b1;
          verdict.sec     = ecc_sec;
          verdict.ded     = ecc_ded;
        end
      end
    endcase
    verdict.bus_err = verdict.ded && (mode == MODE_ECC_ONLY || mode == MODE_DYN);
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int DW        = 32,
  parameter bit HAS_FAULT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          flt_en_i,
  input  logic [2:0]    flt_mask_i,
  input  logic          wr_req_i,
  input  logic          wr_single_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_valid_o,
  output logic          wr_err_o,
  output logic [2:0]    wr_ctl_o,
  output logic          wr_par_o,
  input  logic          rd_valid_i,
  input  logic [2:0]    rd_ctl_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_par_i,
  input  logic          ecc_sec_i,
  input  logic          ecc_ded_i,
  output logic          rsp_valid_o,
  output logic          use_ecc_o,
  output logic          use_par_o,
  output logic          sec_o,
  output logic          ded_o,
  output logic          bus_err_o
);
  prot_mode_e      mode;
  logic            wr_accept, wr_refuse, wr_par_n;
  logic [CTLW-1:0] wr_tag_n;
  logic            vote_narrow, par_mismatch;
  rd_verdict_t     verdict, verdict_q;

  assign mode = prot_mode_e'(mode_i);

  fp_wr_ctl #(.DW(DW)) u_wr (
    .req(wr_req_i), .single(wr_single_i), .mode(mode), .data(wr_data_i),
    .accept(wr_accept), .refuse(wr_refuse), .tag(wr_tag_n), .par(wr_par_n)
  );

  fp_rd_decode #(.DW(DW), .HAS_FAULT(HAS_FAULT)) u_rd (
    .mode(mode), .tag_raw(rd_ctl_i), .flt_en(flt_en_i), .flt_mask(flt_mask_i),
    .data(rd_data_i), .par_bit(rd_par_i), .ecc_sec(ecc_sec_i), .ecc_ded(ecc_ded_i),
    .vote_narrow(vote_narrow), .par_mismatch(par_mismatch), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      wr_err_o   <= 1'b0;
      wr_ctl_o   <= '0;
      wr_par_o   <= 1'b0;
    end else begin
      wr_valid_o <= wr_accept;
      wr_err_o   <= wr_refuse;
      wr_ctl_o   <= wr_tag_n;
      wr_par_o   <= wr_par_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      verdict_q   <= '0;
    end else begin
      rsp_valid_o <= rd_valid_i;
      verdict_q   <= rd_valid_i ? verdict : '0;
    end
  end

  assign use_ecc_o = verdict_q.use_ecc;
  assign use_par_o = verdict_q.use_par;
  assign sec_o     = verdict_q.sec;
  assign ded_o     = verdict_q.ded;
  assign bus_err_o = verdict_q.bus_err;
endmodule

// File: rtl/fp_prot_chk.sv
module fp_prot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       wr_req_i,
  input logic       wr_single_i,
  input logic       wr_valid_o,
  input logic       wr_err_o,
  input logic [2:0] wr_ctl_o,
  input logic       rsp_valid_o,
  input logic       use_ecc_o,
  input logic       use_par_o,
  input logic       sec_o,
  input logic       ded_o,
  input logic       bus_err_o
);
  AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(mode_i) == 2'b11 |-> !use_ecc_o && !use_par_o && !ded_o && !sec_o && !bus_err_o); // R1
  AST_FULL_WRITE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_i && !wr_single_i |=> wr_valid_o && wr_ctl_o == 3'b000); // R2
  AST_NARROW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_i && wr_single_i && mode_i == 2'b00 |=> wr_err_o && !wr_valid_o); // R4
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({use_ecc_o, use_par_o})); // R5
  AST_PARITY_NO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    use_par_o |-> !sec_o); // R7
  AST_QUIET_NO_BUSERR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(mode_i) == 2'b10 |-> !bus_err_o); // R8
  AST_ECC_ONLY_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && $past(mode_i) == 2'b00 |-> use_ecc_o); // R9
  AST_FLAGS_NEED_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid_o |-> !use_ecc_o && !use_par_o && !ded_o && !bus_err_o); // R11
endmodule

bind flash_prot_ctrl fp_prot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_req_i(wr_req_i),
  .wr_single_i(wr_single_i), .wr_valid_o(wr_valid_o), .wr_err_o(wr_err_o),
  .wr_ctl_o(wr_ctl_o), .rsp_valid_o(rsp_valid_o), .use_ecc_o(use_ecc_o),
  .use_par_o(use_par_o), .sec_o(sec_o), .ded_o(ded_o), .bus_err_o(bus_err_o)
);

// File: tb/sim_flash_prot_ctrl.sv
module sim_flash_prot_ctrl;
  localparam int DW = 32;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic flt_en = 0; logic [2:0] flt_mask = '0;
  logic wr_req = 0, wr_single = 0; logic [DW-1:0] wr_data = '0;
  logic wr_valid, wr_err, wr_par; logic [2:0] wr_ctl;
  logic rd_valid = 0, rd_par = 0, esec = 0, eded = 0;
  logic [2:0] rd_ctl = '0; logic [DW-1:0] rd_data = '0;
  logic rsp_valid, use_ecc, use_par, sec, ded, bus_err;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // expected outputs for the next sampling point
  logic [11:0] exp_out;
  string tag_now;

  always #(TCLK/2) clk = ~clk;

  flash_prot_ctrl #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .flt_en_i(flt_en), .flt_mask_i(flt_mask),
    .wr_req_i(wr_req), .wr_single_i(wr_single), .wr_data_i(wr_data),
    .wr_valid_o(wr_valid), .wr_err_o(wr_err), .wr_ctl_o(wr_ctl), .wr_par_o(wr_par),
    .rd_valid_i(rd_valid), .rd_ctl_i(rd_ctl), .rd_data_i(rd_data), .rd_par_i(rd_par),
    .ecc_sec_i(esec), .ecc_ded_i(eded), .rsp_valid_o(rsp_valid), .use_ecc_o(use_ecc),
    .use_par_o(use_par), .sec_o(sec), .ded_o(ded), .bus_err_o(bus_err)
  );

  // behavioural model: order {wr_valid,wr_err,wr_ctl[2:0],wr_par,rsp,ecc,par,sec,ded,berr}
  function automatic logic [11:0] model();
    logic [11:0] r = '0;
    int ones;
    logic pe;
    if (wr_req) begin
      if (wr_single && mode == 2'd0) r[10] = 1;
      else begin
        r[11] = 1;
        if (wr_single) begin r[9:7] = 3'd7; r[6] = ($countones(wr_data) % 2) == 1; end
      end
    end
    if (rd_valid) begin
      r[5] = 1;
      ones = $countones(flt_en ? (rd_ctl ^ flt_mask) : rd_ctl);
      pe = (($countones(rd_data) + (rd_par ? 1 : 0)) % 2) == 1;
      if (mode == 2'd3) ;
      else if (mode == 2'd0 || ones < 2) begin r[4] = 1; r[2] = esec; r[1] = eded; end
      else begin r[3] = 1; r[1] = pe; end
      if (mode == 2'd0 || mode == 2'd1) r[0] = r[1];
    end
    return r;
  endfunction

  function automatic logic [11:0] actual();
    return {wr_valid, wr_err, wr_ctl, wr_par, rsp_valid, use_ecc, use_par, sec, ded, bus_err};
  endfunction

  task automatic compare(input string t, input logic [11:0] e);
    compared++;
    if (actual() !== e) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b", t, actual(), e);
    end
  endtask

  // apply inputs after a falling edge, compare at the following falling edge
  task automatic step(input string t);
    exp_out = model();
    @(negedge clk);
    compare(t, exp_out);
    wr_req = 0; rd_valid = 0;
  endtask

  task automatic do_read(input logic [1:0] m, input logic [2:0] c, input logic fe,
                         input logic [2:0] fm, input logic [DW-1:0] d, input logic p,
                         input logic s, input logic dd, input string t);
    mode = m; rd_ctl = c; flt_en = fe; flt_mask = fm; rd_data = d; rd_par = p;
    esec = s; eded = dd; rd_valid = 1;
    step(t);
  endtask

  task automatic do_write(input logic [1:0] m, input logic sg, input logic [DW-1:0] d,
                          input string t);
    mode = m; wr_single = sg; wr_data = d; wr_req = 1;
    step(t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R12 reset", 12'd0);
    rst_n = 1;
    step("R11 idle");
    // writes
    for (int m = 0; m < 4; m++) begin
      do_write(m[1:0], 1'b0, 32'hA5A5_0F0F, "R2 full write");
      do_write(m[1:0], 1'b1, 32'h0000_0001, m == 0 ? "R4 narrow refused" : "R3 narrow odd data");
      do_write(m[1:0], 1'b1, 32'h0000_0003, m == 0 ? "R4 narrow refused" : "R3 narrow even data");
      step("R11 idle after write");
    end
    // exhaustive tag x mask x mode sweep
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 16; f++) begin
          string t;
          t = (m == 3) ? "R1 bypass" : (m == 0) ? "R9 ecc only" :
              (f[3] ? "R10 fault mask" : "R5 vote");
          do_read(m[1:0], c[2:0], f[3], f[2:0], 32'h1234_5678 ^ c, f[0], f[1], f[2], t);
        end
    // error reporting
    for (int m = 0; m < 4; m++) begin
      do_read(m[1:0], 3'b000, 0, 3'b000, 32'h0, 0, 1, 0, "R6 ecc sec");
      do_read(m[1:0], 3'b010, 0, 3'b000, 32'h0, 0, 0, 1, "R8 ecc ded bus error");
      do_read(m[1:0], 3'b111, 0, 3'b000, 32'h7, 0, 0, 0, "R7 parity mismatch");
      do_read(m[1:0], 3'b101, 1, 3'b111, 32'h7, 1, 1, 1, "R10 mask ignored? flipped");
      do_read(m[1:0], 3'b011, 0, 3'b101, 32'h7, 1, 1, 1, "R10 mask unused when off");
      do_read(m[1:0], 3'b110, 0, 3'b000, 32'hF, 0, 1, 1, "R7 parity clean");
    end
    // random mix, reads and writes together
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      mode = rv[1:0]; rd_ctl = rv[4:2]; flt_en = rv[5]; flt_mask = rv[8:6];
      rd_par = rv[9]; esec = rv[10]; eded = rv[11]; rd_valid = rv[12];
      wr_req = rv[13]; wr_single = rv[14]; wr_data = $urandom; rd_data = $urandom;
      step("R11 mixed traffic");
    end
    rst_n = 0;
    #1;
    compare("R12 reset mid-run", 12'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule